// File: doc/BRIEF.md
# Trail Trace Message Capture

This block collects a 16-octet path trace message that arrives one octet per frame in a dedicated overhead byte of an incoming E3 stream. The upstream framer hands over one trace octet per frame on a valid/ready stream. The block stores the octets in a small register file, which a host reads back over a simple read port. Message alignment comes only from the most significant bit of each octet. An octet whose MSB is 1 marks the first octet of a message. It always restarts capture at entry 0 and raises a change event, whatever happened before it.

The change event sets a sticky flag, which the host sees as bit 6 of a status byte. Reading the status byte clears the flag. An interrupt pin follows the flag while the enable input is high. The block does not check the CRC-7 carried in entry 0, and it does not compare a new message with the previous one.

The input stream never applies back-pressure. `oct_ready` is held at 1 at all times, so each cycle in which `oct_valid` is high transfers one octet. The upstream side needs no holding register.

Top module: `trail_trace_capture`

## Requirements
- R1: After reset, all 16 buffer entries read 0x00, the status byte reads 0x00, `host_rdata` is 0x00 and `irq` is 0.
- R2: A transferred octet with bit 7 = 1 is written into entry 0 and starts a message.
- R3: After a start, each following transferred octet with bit 7 = 0 is written into the next entry in order (1, 2, … 15).
- R4: After entry 15 has been written, further octets with bit 7 = 0 change no entry until the next start octet.
- R5: Octets with bit 7 = 0 that arrive before any start octet has been seen since reset change no entry.
- R6: Every start octet sets the change flag (status bit 6) and restarts capture at entry 0. This holds however many frames have passed since the last start, including during a message that has not finished.
- R7: A host read of address 16 returns the status byte: bit 6 is the change flag and the other bits are 0. The read clears the flag.
- R8: `irq` is 1 exactly while the change flag is set and `irq_en` is 1.
- R9: If a status read and a start octet fall in the same cycle, the read returns the old flag value and the flag stays set.
- R10: `oct_ready` is always 1. While `oct_valid` is 0, `oct_data` has no effect.
- R11: A read pulse with `host_addr` 0–15 returns that buffer entry on `host_rdata` one clock later. An address of 17 or higher returns 0x00. `host_rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oct_valid | input | 1 | Trace octet valid |
| oct_ready | output | 1 | Always 1; the block never stalls the stream |
| oct_data | input | 8 | Trace octet; bit 7 marks the message start |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 5 | 0–15 buffer entry, 16 status byte |
| host_rdata | output | 8 | Read data, registered one cycle after the strobe |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Change interrupt |

## Verification
The main capture path is driven with several full messages whose contents are computed from the message number and the entry index. Idle gaps of different lengths are placed between octets, and an all-ones byte sits on the data lines while valid is low. This separates correct indexing from indexing that is off by one, and separates strobe-qualified capture from capture that ignores valid. Each full message is followed by trailing MSB=0 octets, and a stream with no start octet is sent after reset. These show whether the write pointer stops at entry 15 and whether it stays idle before the first start. A start octet sent in the middle of a message leaves a mix of new and old entries that is only correct after a true restart. A status read in the same cycle as a start checks the priority of the event over the clear.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam int TTC_OCT_W = 8;
  typedef logic [TTC_OCT_W-1:0] octet_t;
  typedef enum logic [0:0] {
    TTC_IDLE = 1'b0,
    TTC_FILL = 1'b1
  } cap_state_e;
endpackage

// File: rtl/ttc_seq.sv
module ttc_seq #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_msb,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic             start_evt
);
  import ttc_pkg::*;

  cap_state_e       state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             is_start;
  logic             is_body;
  logic             at_last;

  always_comb begin
    is_start  = in_valid && in_msb;
    is_body   = in_valid && !in_msb && (state_q == TTC_FILL);
    at_last   = (ptr_q == PTR_W'(DEPTH - 1));
    wr_en     = is_start || is_body;
    wr_idx    = is_start ? '0 : ptr_q;
    start_evt = is_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TTC_IDLE;
      ptr_q   <= '0;
    end else if (is_start) begin
      state_q <= TTC_FILL;
      ptr_q   <= PTR_W'(1);
    end else if (is_body) begin
      if (at_last) begin
        state_q <= TTC_IDLE;
        ptr_q   <= '0;
      end else begin
        ptr_q <= ptr_q + PTR_W'(1);
      end
    end
  end

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_msb) |=> (state_q == TTC_FILL && ptr_q == PTR_W'(1))); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_msb && state_q == TTC_FILL && ptr_q != PTR_W'(DEPTH - 1))
      |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R3

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_msb && state_q == TTC_FILL && ptr_q == PTR_W'(DEPTH - 1))
      |=> (state_q == TTC_IDLE)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TTC_IDLE && !(in_valid && in_msb)) |=> (state_q == TTC_IDLE)); // R5

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/ttc_store.sv
module ttc_store #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  ttc_pkg::octet_t   wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output ttc_pkg::octet_t   rd_data
);
  import ttc_pkg::*;

  octet_t             mem_q [DEPTH];
  logic [DEPTH-1:0]   sel;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign sel[e] = wr_en && (wr_idx == PTR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[e] <= '0;
      else if (sel[e]) mem_q[e] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

  AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_data))); // R2
endmodule

// File: rtl/ttc_flag.sv
module ttc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q && irq_en;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_req) |=> flag_q); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag_q); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en); // R8
endmodule

// File: rtl/ttc_rport.sv
module ttc_rport #(
  parameter int DEPTH    = 16,
  parameter int STAT_BIT = 6,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int ADDR_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  ttc_pkg::octet_t   entry,
  input  logic              flag,
  output logic [PTR_W-1:0]  entry_idx,
  output logic              stat_rd,
  output ttc_pkg::octet_t   rdata
);
  import ttc_pkg::*;

  octet_t rdata_q;
  octet_t stat_byte;
  octet_t mux_out;
  logic   in_buf;
  logic   is_stat;

  always_comb begin
    in_buf    = (addr < ADDR_W'(DEPTH));
    is_stat   = (addr == ADDR_W'(DEPTH));
    entry_idx = addr[PTR_W-1:0];
    stat_byte = '0;
    stat_byte[STAT_BIT] = flag;
    if (in_buf)       mux_out = entry;
    else if (is_stat) mux_out = stat_byte;
    else              mux_out = '0;
    stat_rd = rd && is_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= mux_out;
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q)); // R11

  AST_STAT_ONLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_stat) |=> ($countones(rdata_q) <= 1)); // R7
endmodule

// File: rtl/trail_trace_capture.sv
module trail_trace_capture #(
  parameter int DEPTH    = 16,
  parameter int STAT_BIT = 6,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int ADDR_W  = PTR_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            oct_valid,
  output logic                            oct_ready,
  input  logic [ttc_pkg::TTC_OCT_W-1:0]   oct_data,
  input  logic                            host_rd,
  input  logic [ADDR_W-1:0]               host_addr,
  output logic [ttc_pkg::TTC_OCT_W-1:0]   host_rdata,
  input  logic                            irq_en,
  output logic                            irq
);
  import ttc_pkg::*;

  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic             start_evt;
  logic [PTR_W-1:0] rd_idx;
  octet_t           rd_entry;
  logic             flag;
  logic             stat_rd;

  assign oct_ready = 1'b1;

  ttc_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (oct_valid),
    .in_msb    (oct_data[TTC_OCT_W-1]),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .start_evt (start_evt)
  );

  ttc_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (oct_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_entry)
  );

  ttc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (start_evt),
    .clr_req (stat_rd),
    .irq_en  (irq_en),
    .flag    (flag),
    .irq     (irq)
  );

  ttc_rport #(.DEPTH(DEPTH), .STAT_BIT(STAT_BIT)) u_rport (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (host_rd),
    .addr      (host_addr),
    .entry     (rd_entry),
    .flag      (flag),
    .entry_idx (rd_idx),
    .stat_rd   (stat_rd),
    .rdata     (host_rdata)
  );

  AST_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_valid && oct_data[TTC_OCT_W-1]) |=> flag); // R6

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(oct_valid && oct_data[TTC_OCT_W-1])) |=> !flag); // R10
endmodule

// File: tb/test_trail_trace_capture.sv
module test_trail_trace_capture;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       oct_valid;
  logic       oct_ready;
  logic [7:0] oct_data;
  logic       host_rd;
  logic [4:0] host_addr;
  logic [7:0] host_rdata;
  logic       irq_en;
  logic       irq;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  logic [7:0] mdl [16];
  int  mptr;
  bit  mact;
  bit  mstat;

  always #5 clk = ~clk;

  trail_trace_capture i_trail_trace_capture (
    .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid), .oct_ready(oct_ready),
    .oct_data(oct_data), .host_rd(host_rd), .host_addr(host_addr),
    .host_rdata(host_rdata), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_oct(input logic [7:0] b);
    if (b[7]) begin
      mdl[0] = b; mptr = 1; mact = 1; mstat = 1;
    end else if (mact) begin
      mdl[mptr] = b;
      if (mptr == 15) mact = 0; else mptr++;
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    oct_valid = 1'b1; oct_data = b;
    @(negedge clk);
    oct_valid = 1'b0; oct_data = 8'hFF;
    model_oct(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 5'(a);
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
    if (a == 16) mstat = 0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(i, d);
      chk(req, d, mdl[i]);
    end
  endtask

  task automatic check_stat(input string req);
    logic [7:0] d;
    logic [7:0] e;
    chk("R8 irq", irq, mstat & irq_en);
    e = mstat ? 8'h40 : 8'h00;
    rd(16, d);
    chk(req, d, e);
    chk("R7 irq after read", irq, 1'b0);
    rd(16, d);
    chk("R7 cleared", d, 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    bit old;
    rst_n = 1'b0; oct_valid = 1'b0; oct_data = 8'hFF;
    host_rd = 1'b0; host_addr = '0; irq_en = 1'b1;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mptr = 0; mact = 0; mstat = 0;
    idle(3);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rdata", host_rdata, 8'h00);
    rst_n = 1'b1;
    idle(2);
    check_all("R1 entries");
    check_stat("R1 status");

    send(8'h11); send(8'h22); send(8'h7F);
    check_all("R5 no start");
    chk("R5 irq", irq, 1'b0);
    chk("R10 ready", oct_ready, 1'b1);

    for (int k = 0; k < 6; k++) begin
      irq_en = k[0];
      send(8'h80 | 8'(k));
      chk("R8 irq after start", irq, k[0]);
      rd(0, d);
      chk("R2 entry0", d, 8'h80 | 8'(k));
      for (int i = 1; i < 16; i++) begin
        send(8'((i * 13 + k * 5) & 8'h7F));
        idle(k);
      end
      for (int j = 0; j < 4; j++) send(8'((j * 3 + 1) & 8'h7F));
      check_all("R3 R4 message");
      check_stat("R6 status");
    end

    irq_en = 1'b1;
    send(8'h85);
    for (int i = 1; i < 6; i++) send(8'(i * 9));
    send(8'h86);
    for (int i = 1; i < 4; i++) send(8'(i + 8'h30));
    check_all("R6 restart");
    check_stat("R6 restart status");

    old = mstat;
    @(negedge clk);
    oct_valid = 1'b1; oct_data = 8'h87; host_rd = 1'b1; host_addr = 5'd16;
    @(negedge clk);
    oct_valid = 1'b0; oct_data = 8'hFF; host_rd = 1'b0;
    chk("R9 old value", host_rdata, old ? 8'h40 : 8'h00);
    model_oct(8'h87);
    chk("R9 irq kept", irq, 1'b1);
    check_stat("R9 flag kept");

    rd(17, d); chk("R11 addr17", d, 8'h00);
    rd(31, d); chk("R11 addr31", d, 8'h00);
    idle(3);
    chk("R11 hold", host_rdata, 8'h00);
    rd(0, d); chk("R11 entry0", d, 8'h87);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule